// File: doc/BRIEF.md
# AES-128 Key Expansion Unit

This unit turns a 128-bit cipher key into the 44 words of the AES-128 key schedule. After a start pulse it produces one 32-bit schedule word per clock, W(0) through W(43), each with a valid strobe and its index. Whenever a word completes a group of four, the same cycle also presents the full 128-bit round key for that group together with its round number. A cipher datapath can therefore consume the schedule either word by word or one round key at a time.

The first four words are the key itself. Each later word is the XOR of the word four places back with either the previous word or, at every fourth position, a transformed copy of the previous word. That transform rotates the bytes, passes each byte through the AES substitution box and XORs in a round constant. The substitution box is computed from the field inverse followed by the affine map, so there is no stored table. The round constant comes from repeated doubling in GF(2^8).

Top module: `aes128_key_sched`

## Requirements
- R1: After reset, `busy`, `wvalid`, `rkvalid` and `done` are all 0.
- R2: A `start` sampled while `busy` is 0 latches `key` and sets `busy` at that edge. Words W(0)..W(43) then appear on 44 consecutive cycles, W(0) after the following edge, each with `wvalid`=1 and `widx` equal to its index.
- R3: W(0)..W(3) are the key slices: W(0)=`key[127:96]`, W(1)=`key[95:64]`, W(2)=`key[63:32]`, W(3)=`key[31:0]`.
- R4: For i >= 4 with i mod 4 != 0, W(i) = W(i-4) XOR W(i-1).
- R5: For i >= 4 with i mod 4 = 0, W(i) = W(i-4) XOR T(W(i-1)). With bytes a=[31:24], b=[23:16], c=[15:8], d=[7:0], T rotates (a,b,c,d) to (b,c,d,a), substitutes every byte, then XORs the round constant into the top byte [31:24].
- R6: The byte substitution is the GF(2^8) multiplicative inverse modulo x^8+x^4+x^3+x+1 (0 maps to 0), followed by the affine map s = v ^ rotl(v,1) ^ rotl(v,2) ^ rotl(v,3) ^ rotl(v,4) ^ 0x63. For example, byte 00 maps to 63, so an all-zero key gives W(4)=62636363.
- R7: The round constant is 01 for W(4). Each later multiple-of-four word doubles it in GF(2^8), giving 01,02,04,08,10,20,40,80,1B,36. The sequence restarts at 01 on every accepted start.
- R8: When the word with index i, i mod 4 = 3, is presented, `rkvalid`=1, `rkidx`=i/4 and `rkey` = {W(i-3),W(i-2),W(i-1),W(i)} with W(i-3) in bits [127:96]. In all other cycles `rkvalid`=0.
- R9: `done` pulses for exactly the cycle that presents W(43). `busy` is 0 from that cycle on. A `start` seen while `busy` is 1 has no effect on the words produced.
- R10: For key 2B7E151628AED2A6ABF7158809CF4F3C, W(4)=A0FAFE17 and W(43)=B6630CA6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an expansion of `key` when idle |
| key | input | 128 | Cipher key |
| busy | output | 1 | Expansion in progress |
| wvalid | output | 1 | `word` and `widx` are valid |
| widx | output | 6 | Index of the presented word, 0..43 |
| word | output | 32 | Schedule word W(widx) |
| rkvalid | output | 1 | `rkey` and `rkidx` are valid |
| rkidx | output | 4 | Round number of `rkey`, 0..10 |
| rkey | output | 128 | Complete round key |
| done | output | 1 | Pulse with the last word |

## Verification
The block has no parameters, because AES-128 fixes every width and count. The bench therefore builds its single configuration, in which each run walks all 44 word positions, all eleven round keys and all ten round constants, including the reduced values 1B and 36. Directed keys (the standard vector, all zeros, all ones) and seeded random keys are compared against a reference schedule. That reference computes the substitution by a brute-force inverse search. One run also pokes `start` mid-expansion to show it is ignored.

// File: rtl/aes128_key_sched.sv
module aes128_key_sched (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] key,
  output logic         busy,
  output logic         wvalid,
  output logic [5:0]   widx,
  output logic [31:0]  word,
  output logic         rkvalid,
  output logic [3:0]   rkidx,
  output logic [127:0] rkey,
  output logic         done
);

  localparam logic [5:0] LAST = 6'd43;

  function automatic logic [7:0] xt(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] v);
    logic [7:0] sq, acc;
    sq  = v;
    acc = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gmul(sq, sq);
      acc = gmul(acc, sq);
    end
    return acc ^ {acc[6:0], acc[7]} ^ {acc[5:0], acc[7:6]}
               ^ {acc[4:0], acc[7:5]} ^ {acc[3:0], acc[7:4]} ^ 8'h63;
  endfunction

  logic [31:0] w0, w1, w2, w3;
  logic [5:0]  idx;
  logic [7:0]  rc;

  logic        grow, head;
  logic [31:0] rotw, subw, nxt, cur;

  assign grow = idx >= 6'd4;
  assign head = idx[1:0] == 2'd0;
  assign rotw = {w3[23:0], w3[31:24]};
  assign subw = {sbox(rotw[31:24]), sbox(rotw[23:16]), sbox(rotw[15:8]), sbox(rotw[7:0])};
  assign nxt  = w0 ^ (head ? (subw ^ {rc, 24'h000000}) : w3);

  always_comb begin
    case (idx[1:0])
      2'd0:    cur = w0;
      2'd1:    cur = w1;
      2'd2:    cur = w2;
      default: cur = w3;
    endcase
    if (grow) cur = nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wvalid  <= 1'b0;
      widx    <= '0;
      word    <= '0;
      rkvalid <= 1'b0;
      rkidx   <= '0;
      rkey    <= '0;
      done    <= 1'b0;
      w0 <= '0; w1 <= '0; w2 <= '0; w3 <= '0;
      idx <= '0;
      rc  <= 8'h01;
    end else begin
      wvalid  <= 1'b0;
      rkvalid <= 1'b0;
      done    <= 1'b0;
      if (!busy) begin
        if (start) begin
          w0 <= key[127:96]; w1 <= key[95:64]; w2 <= key[63:32]; w3 <= key[31:0];
          idx  <= '0;
          rc   <= 8'h01;
          busy <= 1'b1;
        end
      end else begin
        wvalid <= 1'b1;
        widx   <= idx;
        word   <= cur;
        if (idx[1:0] == 2'd3) begin
          rkvalid <= 1'b1;
          rkidx   <= idx[5:2];
          rkey    <= grow ? {w1, w2, w3, nxt} : {w0, w1, w2, w3};
        end
        if (grow) begin
          w0 <= w1; w1 <= w2; w2 <= w3; w3 <= nxt;
          if (head) rc <= xt(rc);
        end
        idx <= idx + 6'd1;
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/aes128_key_sched_chk.sv
module aes128_key_sched_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [127:0] key,
  input logic         busy,
  input logic         wvalid,
  input logic [5:0]   widx,
  input logic [31:0]  word,
  input logic         rkvalid,
  input logic [3:0]   rkidx,
  input logic [127:0] rkey,
  input logic         done
);

  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !wvalid)); // R2

  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wvalid) |-> (widx == 6'd0)); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && widx != 6'd43) |=> (wvalid && widx == $past(widx) + 6'd1)); // R2

  AST_RK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rkvalid |-> (wvalid && widx[1:0] == 2'd3 && rkidx == widx[5:2])); // R8

  AST_RK_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rkvalid |-> (rkey[31:0] == word)); // R8

  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wvalid && widx == 6'd43 && !busy)); // R9

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && widx == 6'd43) |-> done); // R9

endmodule

bind aes128_key_sched aes128_key_sched_chk u_chk (.*);

// File: tb/test_aes128_key_sched.sv
module test_aes128_key_sched;

  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] key = '0;
  logic         busy, wvalid, rkvalid, done;
  logic [5:0]   widx;
  logic [31:0]  word;
  logic [3:0]   rkidx;
  logic [127:0] rkey;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] ref_w [44];

  always #(PERIOD/2) clk = ~clk;

  aes128_key_sched i_aes128_key_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key),
    .busy(busy), .wvalid(wvalid), .widx(widx), .word(word),
    .rkvalid(rkvalid), .rkidx(rkidx), .rkey(rkey), .done(done)
  );

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int k = 0; k < 8; k++)
      if (b[k]) p = p ^ (15'(a) << k);
    for (int k = 14; k >= 8; k--)
      if (p[k]) p = p ^ (15'h11b << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_sub(input logic [7:0] v);
    logic [7:0] inv, s;
    inv = 8'h00;
    for (int y = 1; y < 256; y++)
      if (fmul(v, 8'(y)) == 8'h01) inv = 8'(y);
    for (int k = 0; k < 8; k++)
      s[k] = inv[k] ^ inv[(k+4)%8] ^ inv[(k+5)%8] ^ inv[(k+6)%8] ^ inv[(k+7)%8];
    return s ^ 8'h63;
  endfunction

  task automatic expand(input logic [127:0] k);
    logic [7:0] rcon;
    logic [31:0] t;
    rcon = 8'h01;
    for (int i = 0; i < 4; i++) ref_w[i] = k[127 - 32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = ref_w[i-1];
      if (i % 4 == 0) begin
        t = {ref_sub(t[23:16]) ^ rcon, ref_sub(t[15:8]), ref_sub(t[7:0]), ref_sub(t[31:24])};
        rcon = fmul(rcon, 8'h02);
      end
      ref_w[i] = ref_w[i-4] ^ t;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [127:0] k, input bit poke);
    expand(k);
    @(negedge clk);
    start = 1'b1;
    key = k;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !wvalid, "R2 busy after start", {busy, wvalid}, 2'b10);
    for (int i = 0; i < 44; i++) begin
      if (poke && i == 10) begin
        start = 1'b1;
        key = ~k;
      end else start = 1'b0;
      @(negedge clk);
      chk(wvalid && widx == 6'(i), "R2 valid/index", {wvalid, widx}, {1'b1, 6'(i)});
      if (i < 4)
        chk(word == ref_w[i], "R3 key word", word, ref_w[i]);
      else if (i % 4 == 0)
        chk(word == ref_w[i], "R5 R6 R7 transformed word", word, ref_w[i]);
      else
        chk(word == ref_w[i], poke ? "R9 R4 plain word with ignored start" : "R4 plain word", word, ref_w[i]);
      if (i % 4 == 3)
        chk(rkvalid && rkidx == 4'(i/4) && rkey == {ref_w[i-3], ref_w[i-2], ref_w[i-1], ref_w[i]},
            "R8 round key", {rkvalid, rkidx, rkey}, {1'b1, 4'(i/4), ref_w[i-3], ref_w[i-2], ref_w[i-1], ref_w[i]});
      else
        chk(!rkvalid, "R8 no round key", rkvalid, 1'b0);
      chk(done == (i == 43), "R9 done timing", done, (i == 43));
    end
    start = 1'b0;
    @(negedge clk);
    chk(!wvalid && !done && !busy, "R9 idle after last", {wvalid, done, busy}, 3'b000);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_a35);
    repeat (3) @(negedge clk);
    chk(!busy && !wvalid && !rkvalid && !done, "R1 reset state",
        {busy, wvalid, rkvalid, done}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wvalid && !rkvalid && !done, "R1 idle after reset",
        {busy, wvalid, rkvalid, done}, 4'b0000);

    run(128'h2B7E151628AED2A6ABF7158809CF4F3C, 1'b0);
    chk(ref_w[4] == 32'hA0FAFE17, "R10 reference W4", ref_w[4], 32'hA0FAFE17);
    chk(ref_w[43] == 32'hB6630CA6, "R10 reference W43", ref_w[43], 32'hB6630CA6);
    run(128'h0, 1'b0);
    chk(ref_w[4] == 32'h62636363, "R6 zero-key W4", ref_w[4], 32'h62636363);
    run({128{1'b1}}, 1'b0);
    run(128'h000102030405060708090A0B0C0D0E0F, 1'b1);
    for (int r = 0; r < 6; r++)
      run({$urandom, $urandom, $urandom, $urandom}, r == 2);
    run(128'h2B7E151628AED2A6ABF7158809CF4F3C, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule